// File: doc/BRIEF.md
# Dual-Bank Bidirectional Transfer Buffer

This block is the data buffer of one transfer channel between a local-bus port and a PCI-side port that share one clock. It holds two banks of eight 32-bit words (32 bytes each). The producer side loads one bank while the consumer side empties the other, so both buses can move data in the same cycle. A run-time direction bit decides which port is the producer. With direction 0 the local port fills and the PCI port drains. With direction 1 the PCI port fills and the local port drains.

Each bank runs its own four-state machine:

- `BK_EMPTY` goes to `BK_FILLING` on a first write that does not close the burst, or straight to `BK_FULL` on a first write that does.
- `BK_FILLING` goes to `BK_FULL` on the eighth word or on a word flagged last.
- `BK_FULL` goes to `BK_DRAINING` on a first read that is not the final valid word, or straight back to `BK_EMPTY` when it is.
- `BK_DRAINING` goes to `BK_EMPTY` on the read of the final valid word.

A bank that closes early keeps its word count, so the consumer reads only the valid words. The fill pointer moves to the other bank when a burst closes. The drain pointer moves when a bank has been read out.

A small direction machine has two states, `DIR_LOC2PCI` and `DIR_PCI2LOC`. It moves between them only when both banks are `BK_EMPTY` and no write is accepted in that cycle. A synchronous soft reset empties both banks, returns both pointers to bank 0 and restores `DIR_LOC2PCI`.

Top module: `pp_xfer_buffer`

## Requirements
- R1: After the hardware reset, both banks are empty and the direction is 0. The producer request of the local port is 1, the producer request of the PCI port is 0, and both consumer requests are 0.
- R2: Direction 0 makes the local port the producer and the PCI port the consumer; direction 1 swaps them. Requests on the non-selected side read 0, its read data reads 0, and its writes and reads are ignored.
- R3: Eight accepted writes into one bank mark it full. The fill pointer moves to the other bank, so the producer request stays 1 and the consumer request becomes 1 in the next cycle.
- R4: A write with the last flag closes the bank with that word count. The read-last output is 1 exactly while the word being presented is the final valid word of the drain bank. After that word is read, the bank is empty.
- R5: Read data is shown ahead, before the read. Words come out in the order they were written, and banks are drained in the order they were filled.
- R6: The producer request is 1 only while the current fill bank is empty or filling. With both banks holding data it is 0, and writes are ignored.
- R7: The consumer request is 1 only while the current drain bank is full or draining. Reads without it are ignored.
- R8: A write into one bank and a read from the other bank are both accepted in the same cycle.
- R9: A new direction value is taken only in a cycle where both banks are empty and no write is accepted. Otherwise the request is ignored.
- R10: The soft reset empties both banks, drops every consumer request and returns the direction to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous clear of buffer state and direction |
| dir_i | input | 1 | Requested direction (0 local-to-PCI, 1 PCI-to-local) |
| dir_o | output | 1 | Direction in effect |
| loc_wr_en | input | 1 | Local-port word write |
| loc_wr_data | input | 32 | Local-port write word |
| loc_wr_last | input | 1 | Local-port write closes the burst |
| loc_fill_req | output | 1 | Local port may write a word |
| loc_rd_en | input | 1 | Local-port word read |
| loc_rd_data | output | 32 | Local-port read word, shown ahead |
| loc_rd_last | output | 1 | Shown local word is the last valid one of its bank |
| loc_drain_req | output | 1 | Local port has a word to read |
| pci_wr_en | input | 1 | PCI-port word write |
| pci_wr_data | input | 32 | PCI-port write word |
| pci_wr_last | input | 1 | PCI-port write closes the burst |
| pci_fill_req | output | 1 | PCI port may write a word |
| pci_rd_en | input | 1 | PCI-port word read |
| pci_rd_data | output | 32 | PCI-port read word, shown ahead |
| pci_rd_last | output | 1 | Shown PCI word is the last valid one of its bank |
| pci_drain_req | output | 1 | PCI port has a word to read |

## Verification
The bench builds the block with its default 32-bit word and eight-word banks. At that depth a full-bank swap takes eight writes, so both ping-pong pointers wrap many times within a few thousand random cycles. The random last flag produces short bursts of every length from one to seven words, including single-word banks that go from `BK_EMPTY` straight to `BK_FULL` and back. The depth is also small enough to reach the both-banks-held stall and a blocked direction change within a handful of cycles.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;

    typedef enum logic [1:0] {
        BK_EMPTY    = 2'd0,
        BK_FILLING  = 2'd1,
        BK_FULL     = 2'd2,
        BK_DRAINING = 2'd3
    } bank_st_e;

    typedef enum logic {
        DIR_LOC2PCI = 1'b0,
        DIR_PCI2LOC = 1'b1
    } xfer_dir_e;

endpackage

// File: rtl/pp_bank.sv
`timescale 1ns/1ps
module pp_bank
    import pp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_fire,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_fire,
    output logic              accepting,
    output logic              holding,
    output logic              is_empty,
    output logic              fill_done,
    output logic              drain_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    bank_st_e          state_q, state_d;
    logic [PTR_W-1:0]  widx_q;
    logic [PTR_W-1:0]  ridx_q;
    logic [CNT_W-1:0]  len_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // burst closes on the last slot or on an explicit last flag
    assign fill_done  = wr_fire && (wr_last || (widx_q == LAST_IDX));
    assign rd_last    = holding && ((CNT_W'(ridx_q) + CNT_W'(1)) == len_q);
    assign drain_done = rd_fire && rd_last;
    assign rd_data    = mem_q[ridx_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_EMPTY;
        end else if (clr) begin
            state_q <= BK_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_EMPTY: begin
                if (wr_fire) state_d = fill_done ? BK_FULL : BK_FILLING;
            end
            BK_FILLING: begin
                if (fill_done) state_d = BK_FULL;
            end
            BK_FULL: begin
                if (rd_fire) state_d = drain_done ? BK_EMPTY : BK_DRAINING;
            end
            BK_DRAINING: begin
                if (drain_done) state_d = BK_EMPTY;
            end
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        accepting = 1'b0;
        holding   = 1'b0;
        is_empty  = 1'b0;
        unique case (state_q)
            BK_EMPTY:    begin accepting = 1'b1; is_empty = 1'b1; end
            BK_FILLING:  accepting = 1'b1;
            BK_FULL:     holding   = 1'b1;
            BK_DRAINING: holding   = 1'b1;
        endcase
    end

    // index and length bookkeeping of the bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q <= '0;
            ridx_q <= '0;
            len_q  <= '0;
        end else if (clr) begin
            widx_q <= '0;
            ridx_q <= '0;
            len_q  <= '0;
        end else begin
            if (fill_done) begin
                widx_q <= '0;
                len_q  <= CNT_W'(widx_q) + CNT_W'(1);
            end else if (wr_fire) begin
                widx_q <= widx_q + PTR_W'(1);
            end
            if (drain_done) begin
                ridx_q <= '0;
            end else if (rd_fire) begin
                ridx_q <= ridx_q + PTR_W'(1);
            end
        end
    end

    // data storage, no reset needed
    always_ff @(posedge clk) begin
        if (wr_fire) mem_q[widx_q] <= wr_data;
    end

endmodule

// File: rtl/pp_dir_ctrl.sv
`timescale 1ns/1ps
module pp_dir_ctrl
    import pp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      dir_req,
    input  logic      all_empty,
    input  logic      wr_fire,
    output xfer_dir_e dir_q
);

    xfer_dir_e dir_d;
    logic      may_switch;

    assign may_switch = all_empty && !wr_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_LOC2PCI;
        end else if (clr) begin
            dir_q <= DIR_LOC2PCI;
        end else begin
            dir_q <= dir_d;
        end
    end

    always_comb begin
        dir_d = dir_q;
        unique case (dir_q)
            DIR_LOC2PCI: if (may_switch && dir_req)  dir_d = DIR_PCI2LOC;
            DIR_PCI2LOC: if (may_switch && !dir_req) dir_d = DIR_LOC2PCI;
        endcase
    end

endmodule

// File: rtl/pp_port_mux.sv
`timescale 1ns/1ps
module pp_port_mux
    import pp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xfer_dir_e         dir,
    input  logic              loc_wr_en,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_wr_last,
    input  logic              loc_rd_en,
    input  logic              pci_wr_en,
    input  logic [DATA_W-1:0] pci_wr_data,
    input  logic              pci_wr_last,
    input  logic              pci_rd_en,
    input  logic              fill_ok,
    input  logic              drain_ok,
    input  logic [DATA_W-1:0] drain_data,
    input  logic              drain_last,
    output logic              fill_wr_en,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_last,
    output logic              drain_rd_en,
    output logic              loc_fill_req,
    output logic              loc_drain_req,
    output logic [DATA_W-1:0] loc_rd_data,
    output logic              loc_rd_last,
    output logic              pci_fill_req,
    output logic              pci_drain_req,
    output logic [DATA_W-1:0] pci_rd_data,
    output logic              pci_rd_last
);

    logic loc_is_src;

    assign loc_is_src = (dir == DIR_LOC2PCI);

    // producer side selection
    assign fill_wr_en = loc_is_src ? loc_wr_en   : pci_wr_en;
    assign fill_data  = loc_is_src ? loc_wr_data : pci_wr_data;
    assign fill_last  = loc_is_src ? loc_wr_last : pci_wr_last;

    // consumer side selection
    assign drain_rd_en = loc_is_src ? pci_rd_en : loc_rd_en;

    assign loc_fill_req  = loc_is_src && fill_ok;
    assign pci_fill_req  = !loc_is_src && fill_ok;
    assign loc_drain_req = !loc_is_src && drain_ok;
    assign pci_drain_req = loc_is_src && drain_ok;

    assign loc_rd_data = loc_drain_req ? drain_data : '0;
    assign pci_rd_data = pci_drain_req ? drain_data : '0;
    assign loc_rd_last = loc_drain_req && drain_last;
    assign pci_rd_last = pci_drain_req && drain_last;

endmodule

// File: rtl/pp_xfer_buffer.sv
`timescale 1ns/1ps
module pp_xfer_buffer
    import pp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int BANK_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              dir_i,
    output logic              dir_o,
    input  logic              loc_wr_en,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_wr_last,
    output logic              loc_fill_req,
    input  logic              loc_rd_en,
    output logic [DATA_W-1:0] loc_rd_data,
    output logic              loc_rd_last,
    output logic              loc_drain_req,
    input  logic              pci_wr_en,
    input  logic [DATA_W-1:0] pci_wr_data,
    input  logic              pci_wr_last,
    output logic              pci_fill_req,
    input  logic              pci_rd_en,
    output logic [DATA_W-1:0] pci_rd_data,
    output logic              pci_rd_last,
    output logic              pci_drain_req
);

    localparam int NBANK = 2;

    xfer_dir_e         dir_q;
    logic              fill_ptr, drain_ptr;
    logic              fill_wr_en, fill_last, drain_rd_en;
    logic [DATA_W-1:0] fill_data;
    logic              fill_ok, drain_ok, fill_fire, drain_fire, all_empty;

    logic [NBANK-1:0]  bk_accept, bk_hold, bk_empty;
    logic [NBANK-1:0]  bk_fill_done, bk_drain_done, bk_rd_last;
    logic [DATA_W-1:0] bk_rd_data [NBANK];

    assign fill_ok    = bk_accept[fill_ptr];
    assign drain_ok   = bk_hold[drain_ptr];
    assign fill_fire  = fill_wr_en && fill_ok;
    assign drain_fire = drain_rd_en && drain_ok;
    assign all_empty  = &bk_empty;
    assign dir_o      = dir_q;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        pp_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_WORDS)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (soft_rst),
            .wr_fire    (fill_fire && (fill_ptr == 1'(g))),
            .wr_data    (fill_data),
            .wr_last    (fill_last),
            .rd_fire    (drain_fire && (drain_ptr == 1'(g))),
            .accepting  (bk_accept[g]),
            .holding    (bk_hold[g]),
            .is_empty   (bk_empty[g]),
            .fill_done  (bk_fill_done[g]),
            .drain_done (bk_drain_done[g]),
            .rd_data    (bk_rd_data[g]),
            .rd_last    (bk_rd_last[g])
        );
    end

    // ping-pong pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_ptr  <= 1'b0;
            drain_ptr <= 1'b0;
        end else if (soft_rst) begin
            fill_ptr  <= 1'b0;
            drain_ptr <= 1'b0;
        end else begin
            if (bk_fill_done[fill_ptr])   fill_ptr  <= ~fill_ptr;
            if (bk_drain_done[drain_ptr]) drain_ptr <= ~drain_ptr;
        end
    end

    pp_dir_ctrl u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .dir_req   (dir_i),
        .all_empty (all_empty),
        .wr_fire   (fill_fire),
        .dir_q     (dir_q)
    );

    pp_port_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .dir           (dir_q),
        .loc_wr_en     (loc_wr_en),
        .loc_wr_data   (loc_wr_data),
        .loc_wr_last   (loc_wr_last),
        .loc_rd_en     (loc_rd_en),
        .pci_wr_en     (pci_wr_en),
        .pci_wr_data   (pci_wr_data),
        .pci_wr_last   (pci_wr_last),
        .pci_rd_en     (pci_rd_en),
        .fill_ok       (fill_ok),
        .drain_ok      (drain_ok),
        .drain_data    (bk_rd_data[drain_ptr]),
        .drain_last    (bk_rd_last[drain_ptr]),
        .fill_wr_en    (fill_wr_en),
        .fill_data     (fill_data),
        .fill_last     (fill_last),
        .drain_rd_en   (drain_rd_en),
        .loc_fill_req  (loc_fill_req),
        .loc_drain_req (loc_drain_req),
        .loc_rd_data   (loc_rd_data),
        .loc_rd_last   (loc_rd_last),
        .pci_fill_req  (pci_fill_req),
        .pci_drain_req (pci_drain_req),
        .pci_rd_data   (pci_rd_data),
        .pci_rd_last   (pci_rd_last)
    );

endmodule

// File: rtl/pp_xfer_buffer_chk.sv
`timescale 1ns/1ps
module pp_xfer_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       dir_o,
    input logic       loc_fill_req,
    input logic       pci_fill_req,
    input logic       loc_drain_req,
    input logic       pci_drain_req,
    input logic       loc_rd_last,
    input logic       pci_rd_last,
    input logic       all_empty,
    input logic [1:0] bk_hold,
    input logic [1:0] bk_fill_done,
    input logic       fill_ptr
);

    p_one_filler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_fill_req && pci_fill_req));

    p_one_drainer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_drain_req && pci_drain_req));

    p_fill_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_fill_done[fill_ptr] && !soft_rst) |=> (fill_ptr != $past(fill_ptr)));

    p_last_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd_last |-> loc_drain_req) and (pci_rd_last |-> pci_drain_req));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&bk_hold) |-> (!loc_fill_req && !pci_fill_req));

    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_empty && !soft_rst) |=> $stable(dir_o));

    p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (all_empty && !loc_drain_req && !pci_drain_req && !dir_o));

endmodule

bind pp_xfer_buffer pp_xfer_buffer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .dir_o         (dir_o),
    .loc_fill_req  (loc_fill_req),
    .pci_fill_req  (pci_fill_req),
    .loc_drain_req (loc_drain_req),
    .pci_drain_req (pci_drain_req),
    .loc_rd_last   (loc_rd_last),
    .pci_rd_last   (pci_rd_last),
    .all_empty     (all_empty),
    .bk_hold       (bk_hold),
    .bk_fill_done  (bk_fill_done),
    .fill_ptr      (fill_ptr)
);

// File: tb/test_pp_xfer_buffer.sv
`timescale 1ns/1ps
module test_pp_xfer_buffer;

    localparam int  W     = 32;
    localparam int  WORDS = 8;
    localparam time TCK   = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, dir_i = 1'b0, dir_o;
    logic loc_wr_en = 1'b0, loc_wr_last = 1'b0, loc_rd_en = 1'b0;
    logic pci_wr_en = 1'b0, pci_wr_last = 1'b0, pci_rd_en = 1'b0;
    logic [W-1:0] loc_wr_data = '0, pci_wr_data = '0, loc_rd_data, pci_rd_data;
    logic loc_fill_req, loc_rd_last, loc_drain_req;
    logic pci_fill_req, pci_rd_last, pci_drain_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit          mdir, fp, dp;
    bit          mfull [2];
    int          mlen [2];
    int          mwc, mrc;
    logic [W-1:0] mmem [2][WORDS];

    always #(TCK/2) clk = ~clk;

    pp_xfer_buffer #(.DATA_W(W), .BANK_WORDS(WORDS)) i_pp_xfer_buffer (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic void model_clear();
        mdir = 0; fp = 0; dp = 0; mwc = 0; mrc = 0;
        for (int b = 0; b < 2; b++) begin mfull[b] = 0; mlen[b] = 0; end
    endfunction

    function automatic bit exp_fill(input bit pci_side);
        return (mdir == pci_side) && !mfull[fp];
    endfunction

    function automatic bit exp_drain(input bit pci_side);
        return (mdir != pci_side) && mfull[dp];
    endfunction

    function automatic logic [W-1:0] exp_data(input bit pci_side);
        return exp_drain(pci_side) ? mmem[dp][mrc] : '0;
    endfunction

    function automatic bit exp_last(input bit pci_side);
        return exp_drain(pci_side) && (mrc + 1 == mlen[dp]);
    endfunction

    function automatic void model_step(input bit lw, input logic [W-1:0] lwd, input bit ll,
                                       input bit lr, input bit pw, input logic [W-1:0] pwd,
                                       input bit pl, input bit pr, input bit d, input bit sr);
        bit ff, df, fl, all_e;
        logic [W-1:0] fd;
        if (sr) begin model_clear(); return; end
        ff    = (mdir ? pw : lw) && !mfull[fp];
        fd    = mdir ? pwd : lwd;
        fl    = mdir ? pl : ll;
        df    = (mdir ? lr : pr) && mfull[dp];
        all_e = !mfull[0] && !mfull[1] && (mwc == 0);
        if (all_e && !ff) mdir = d;
        if (ff) begin
            mmem[fp][mwc] = fd;
            mwc++;
            if (fl || mwc == WORDS) begin
                mfull[fp] = 1; mlen[fp] = mwc; mwc = 0; fp = ~fp;
            end
        end
        if (df) begin
            mrc++;
            if (mrc == mlen[dp]) begin mfull[dp] = 0; mrc = 0; dp = ~dp; end
        end
    endfunction

    task automatic compare_outputs();
        chk(loc_fill_req == exp_fill(0), "R6", "loc_fill_req", W'(loc_fill_req), W'(exp_fill(0)));
        chk(pci_fill_req == exp_fill(1), "R6", "pci_fill_req", W'(pci_fill_req), W'(exp_fill(1)));
        chk(loc_drain_req == exp_drain(0), "R7", "loc_drain_req", W'(loc_drain_req), W'(exp_drain(0)));
        chk(pci_drain_req == exp_drain(1), "R7", "pci_drain_req", W'(pci_drain_req), W'(exp_drain(1)));
        chk(loc_rd_data === exp_data(0), "R5", "loc_rd_data", loc_rd_data, exp_data(0));
        chk(pci_rd_data === exp_data(1), "R5", "pci_rd_data", pci_rd_data, exp_data(1));
        chk(loc_rd_last == exp_last(0), "R4", "loc_rd_last", W'(loc_rd_last), W'(exp_last(0)));
        chk(pci_rd_last == exp_last(1), "R4", "pci_rd_last", W'(pci_rd_last), W'(exp_last(1)));
        chk(dir_o == mdir, "R9", "dir_o", W'(dir_o), W'(mdir));
    endtask

    // drive one cycle: set inputs after the edge, compare before the next, then step the model
    task automatic cyc(input bit lw, input logic [W-1:0] lwd, input bit ll, input bit lr,
                       input bit pw, input logic [W-1:0] pwd, input bit pl, input bit pr,
                       input bit d, input bit sr);
        loc_wr_en = lw; loc_wr_data = lwd; loc_wr_last = ll; loc_rd_en = lr;
        pci_wr_en = pw; pci_wr_data = pwd; pci_wr_last = pl; pci_rd_en = pr;
        dir_i = d; soft_rst = sr;
        #1;
        compare_outputs();
        @(posedge clk);
        model_step(lw, lwd, ll, lr, pw, pwd, pl, pr, d, sr);
        #1;
    endtask

    task automatic idle(input bit d);
        cyc(0, '0, 0, 0, 0, '0, 0, 0, d, 0);
    endtask

    initial begin
        #(TCK * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int unsigned seed;
        bit rdir;
        seed = 32'h5EED_0751;
        void'($urandom(seed));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(loc_fill_req && !pci_fill_req && !loc_drain_req && !pci_drain_req && !dir_o,
            "R1", "reset outputs",
            {27'd0, dir_o, loc_fill_req, pci_fill_req, loc_drain_req, pci_drain_req},
            32'h8);

        // R3 full bank swaps to the other bank
        for (int i = 0; i < WORDS; i++) cyc(1, 32'hA000_0000 + i, 0, 0, 0, '0, 0, 0, 0, 0);
        #1;
        chk(pci_drain_req && loc_fill_req, "R3", "swap after full bank",
            {30'd0, pci_drain_req, loc_fill_req}, 32'h3);

        // R6 both banks held: writes refused
        for (int i = 0; i < WORDS; i++) cyc(1, 32'hB000_0000 + i, 0, 0, 0, '0, 0, 0, 0, 0);
        chk(!loc_fill_req, "R6", "fill req with both banks held", W'(loc_fill_req), 32'h0);
        cyc(1, 32'hDEAD_BEEF, 1, 0, 0, '0, 0, 0, 0, 0);
        chk(!loc_fill_req && pci_drain_req, "R6", "ignored write",
            {30'd0, loc_fill_req, pci_drain_req}, 32'h1);

        // R8 concurrent fill and drain
        for (int i = 0; i < 3 * WORDS; i++) cyc(1, 32'hC000_0000 + i, 0, 0, 0, '0, 0, 1, 0, 0);
        chk(loc_fill_req && pci_drain_req, "R8", "concurrent state",
            {30'd0, loc_fill_req, pci_drain_req}, 32'h3);
        for (int i = 0; i < WORDS; i++) cyc(0, '0, 0, 0, 0, '0, 0, 1, 0, 0);

        // R4 short burst of three words
        for (int i = 0; i < 3; i++) cyc(1, 32'hD000_0000 + i, (i == 2), 0, 0, '0, 0, 0, 0, 0);
        cyc(0, '0, 0, 0, 0, '0, 0, 1, 0, 0);
        cyc(0, '0, 0, 0, 0, '0, 0, 1, 0, 0);
        chk(pci_rd_last && pci_rd_data == 32'hD000_0002, "R4", "last word flag",
            pci_rd_data, 32'hD000_0002);
        cyc(0, '0, 0, 0, 0, '0, 0, 1, 0, 0);
        chk(!pci_drain_req, "R4", "bank empty after short burst", W'(pci_drain_req), 32'h0);

        // R9 direction request while filling is ignored
        cyc(1, 32'hE000_0000, 0, 0, 0, '0, 0, 0, 1, 0);
        idle(1);
        chk(!dir_o, "R9", "dir held while filling", W'(dir_o), 32'h0);
        cyc(1, 32'hE000_0001, 1, 0, 0, '0, 0, 0, 1, 0);
        cyc(0, '0, 0, 0, 0, '0, 0, 1, 1, 0);
        cyc(0, '0, 0, 0, 0, '0, 0, 1, 1, 0);
        idle(1);
        chk(dir_o && pci_fill_req, "R9", "dir taken when empty",
            {30'd0, dir_o, pci_fill_req}, 32'h3);

        // R2 writes from the consumer side are ignored
        for (int i = 0; i < 4; i++) cyc(1, 32'hF000_0000 + i, 1, 0, 0, '0, 0, 0, 1, 0);
        chk(!loc_drain_req && !pci_drain_req && !loc_fill_req && pci_fill_req, "R2",
            "wrong side write",
            {28'd0, loc_drain_req, pci_drain_req, loc_fill_req, pci_fill_req}, 32'h1);
        for (int i = 0; i < 2; i++) cyc(0, '0, 0, 0, 1, 32'h1100_0000 + i, (i == 1), 0, 1, 0);
        chk(loc_drain_req && loc_rd_data == 32'h1100_0000, "R2", "local side drains",
            loc_rd_data, 32'h1100_0000);

        // R10 soft reset mid-traffic
        for (int i = 0; i < WORDS + 3; i++) cyc(0, '0, 0, 0, 1, 32'h2200_0000 + i, 0, 0, 1, 0);
        cyc(0, '0, 0, 0, 0, '0, 0, 0, 1, 1);
        chk(!dir_o && !loc_drain_req && !pci_drain_req && loc_fill_req, "R10", "after soft reset",
            {28'd0, dir_o, loc_drain_req, pci_drain_req, loc_fill_req}, 32'h1);

        // constrained random traffic against the model
        rdir = 1'b0;
        for (int n = 0; n < 6000; n++) begin
            bit src_ok, lw, ll, lr, pw, pl, pr, sr;
            src_ok = ($urandom_range(99) < 85);
            if ($urandom_range(49) == 0) rdir = ~rdir;
            sr = ($urandom_range(499) == 0);
            lw = ($urandom_range(99) < 55) && (mdir == 0 || !src_ok);
            pw = ($urandom_range(99) < 55) && (mdir == 1 || !src_ok);
            ll = ($urandom_range(99) < 15);
            pl = ($urandom_range(99) < 15);
            lr = ($urandom_range(99) < 50);
            pr = ($urandom_range(99) < 50);
            cyc(lw, $urandom, ll, lr, pw, $urandom, pl, pr, rdir, sr);
        end
        finish_run();
    end

endmodule